// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block takes a DDR2 SDRAM from power-up to a state where normal accesses may begin, with no software involvement. Once reset is released it keeps the device deselected with clock enable low for a programmable power-up wait. It then raises clock enable together with the first NOP and steps through a fixed series of commands: NOPs, precharge-all, the loads of the extended mode registers and the mode register, two auto-refreshes, and the two off-chip-driver steps. Each command is followed by the minimum gap that belongs to it.

Each gap is an input given in clock cycles, so one netlist serves any clock frequency and any device speed grade. The contents of the mode register and of extended mode registers 1 and 2 are supplied as address-bit inputs. The sequencer forces only the bits that the series itself controls: DLL reset, DLL enable and the OCD field. When the series ends, a one-cycle done pulse and a held completion flag hand the command bus to the normal-mode scheduler.

Top module: `ddr2_init_seq`

## Requirements
- R1: While reset is low, and from reset release until the first NOP, clock enable is low and the command bus carries deselect ({cs_n,ras_n,cas_n,we_n} = 1111), with bank and address at zero. Both done outputs are low. The first clock edge after reset release starts the power-up wait.
- R2: The first NOP ({cs_n,ras_n,cas_n,we_n} = 0111) appears at clock edge t_pwrup+1 after reset release. Clock enable goes high on that same edge and stays high until the next reset. Whenever clock enable is low, cs_n is high.
- R3: The commands come in this order: NOP, NOP, precharge-all, EMRS2, EMRS3, EMRS1 (DLL enable), MRS (DLL reset), precharge-all, auto-refresh, auto-refresh, MRS (DLL reset cleared), EMRS1 (OCD default), EMRS1 (OCD exit).
- R4: A mode load (0000) selects its target through the bank bits {BA2,BA1,BA0}: MRS 000, EMRS1 001, EMRS2 010, EMRS3 011. The EMRS3 load drives all address bits as zero.
- R5: Mode load addresses are as follows. The first MRS drives mr_cfg with A8 set, and the second drives mr_cfg with A8 cleared. Every EMRS1 drives emr1_cfg with A0 cleared (DLL enabled). A9:A7 are 111 in the OCD-default load and 000 in the other two EMRS1 loads. EMRS2 drives emr2_cfg unchanged.
- R6: The gap from a command's edge to the next command's edge is as follows: t_clk_gap after the first NOP, one cycle after the second NOP, t_rp after each precharge-all, t_rfc after each auto-refresh, and t_mrd after each mode load other than the DLL-enable EMRS1.
- R7: The gap after the DLL-enable EMRS1 is the larger of t_dll and t_mrd.
- R8: Any gap input of zero, t_pwrup included, acts as one cycle.
- R9: Precharge-all is 0010 with A10 high. Auto-refresh is 0001. Between commands, once clock enable is high, the bus carries NOP with bank and address at zero.
- R10: init_done pulses for exactly one cycle, t_mrd cycles after the OCD-exit EMRS1. init_complete rises on the same edge and stays high. From then on the bus carries only NOP.
- R11: A reset asserted at any point in the series returns every output to the R1 state, and the whole series restarts from the power-up wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| t_pwrup | input | CNT_W | Power-up wait before first NOP, cycles |
| t_clk_gap | input | CNT_W | Wait after the clock-enabling NOP, cycles |
| t_rp | input | CNT_W | Gap after precharge-all, cycles |
| t_rfc | input | CNT_W | Gap after auto-refresh, cycles |
| t_mrd | input | CNT_W | Gap after a mode load, cycles |
| t_dll | input | CNT_W | DLL lock wait after DLL enable, cycles |
| mr_cfg | input | ADDR_W | Mode register contents (A8 forced by sequencer) |
| emr1_cfg | input | ADDR_W | EMR1 contents (A0, A9:A7 forced by sequencer) |
| emr2_cfg | input | ADDR_W | EMR2 contents |
| ddr_cke | output | 1 | Clock enable |
| ddr_cs_n | output | 1 | Chip select, active low |
| ddr_ras_n | output | 1 | Row strobe, active low |
| ddr_cas_n | output | 1 | Column strobe, active low |
| ddr_we_n | output | 1 | Write enable, active low |
| ddr_ba | output | BA_W | Bank address |
| ddr_addr | output | ADDR_W | Address bus |
| init_done | output | 1 | One-cycle end-of-series pulse |
| init_complete | output | 1 | Held high once the series has finished |

## Verification
The bench builds the sequencer with an 8-bit counter width and the default 14-bit address and 3-bit bank widths. It sweeps every gap input over small values, zero among them, so that each complete series runs in a few dozen cycles and 96 timing combinations fit in the run. The small values include a DLL wait both above and below t_mrd, which exercises both outcomes of the maximum in R7. Every fifth run is cut short by a reset at a varying cycle, so that the restart is exercised from many points in the series.

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq #(
  parameter int ADDR_W = 14,
  parameter int BA_W   = 3,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  t_pwrup,
  input  logic [CNT_W-1:0]  t_clk_gap,
  input  logic [CNT_W-1:0]  t_rp,
  input  logic [CNT_W-1:0]  t_rfc,
  input  logic [CNT_W-1:0]  t_mrd,
  input  logic [CNT_W-1:0]  t_dll,
  input  logic [ADDR_W-1:0] mr_cfg,
  input  logic [ADDR_W-1:0] emr1_cfg,
  input  logic [ADDR_W-1:0] emr2_cfg,
  output logic              ddr_cke,
  output logic              ddr_cs_n,
  output logic              ddr_ras_n,
  output logic              ddr_cas_n,
  output logic              ddr_we_n,
  output logic [BA_W-1:0]   ddr_ba,
  output logic [ADDR_W-1:0] ddr_addr,
  output logic              init_done,
  output logic              init_complete
);

  localparam logic [3:0] C_DESEL = 4'b1111;
  localparam logic [3:0] C_NOP   = 4'b0111;
  localparam logic [3:0] C_PRE   = 4'b0010;
  localparam logic [3:0] C_REF   = 4'b0001;
  localparam logic [3:0] C_LOAD  = 4'b0000;

  localparam logic [ADDR_W-1:0] M_ALLBANK = ADDR_W'(1) << 10;
  localparam logic [ADDR_W-1:0] M_DLLRST  = ADDR_W'(1) << 8;
  localparam logic [ADDR_W-1:0] M_OCD     = ADDR_W'(7) << 7;
  localparam logic [ADDR_W-1:0] M_DLLOFF  = ADDR_W'(1);

  localparam logic [3:0] S_PWR   = 4'd0;
  localparam logic [3:0] S_NOP1  = 4'd1;
  localparam logic [3:0] S_NOP2  = 4'd2;
  localparam logic [3:0] S_PRE1  = 4'd3;
  localparam logic [3:0] S_EMR2  = 4'd4;
  localparam logic [3:0] S_EMR3  = 4'd5;
  localparam logic [3:0] S_DLLEN = 4'd6;
  localparam logic [3:0] S_MRRST = 4'd7;
  localparam logic [3:0] S_PRE2  = 4'd8;
  localparam logic [3:0] S_REF1  = 4'd9;
  localparam logic [3:0] S_REF2  = 4'd10;
  localparam logic [3:0] S_MRRUN = 4'd11;
  localparam logic [3:0] S_OCDD  = 4'd12;
  localparam logic [3:0] S_OCDX  = 4'd13;
  localparam logic [3:0] S_DONE  = 4'd14;
  localparam logic [3:0] S_IDLE  = 4'd15;

  logic [3:0]        step;
  logic [CNT_W-1:0]  cnt;
  logic [3:0]        cmd_q;
  logic [BA_W-1:0]   ba_q;
  logic [ADDR_W-1:0] addr_q;
  logic              cke_q, done_q, cmpl_q;

  logic [3:0]        nx_cmd;
  logic [BA_W-1:0]   nx_ba;
  logic [ADDR_W-1:0] nx_addr;
  logic [CNT_W-1:0]  nx_gap;
  logic [CNT_W-1:0]  gap_m1;
  logic [CNT_W-1:0]  dll_gap;
  logic [ADDR_W-1:0] emr1_base;

  assign emr1_base = emr1_cfg & ~(M_OCD | M_DLLOFF);
  assign dll_gap   = (t_dll > t_mrd) ? t_dll : t_mrd;
  assign gap_m1    = (nx_gap == '0) ? '0 : nx_gap - 1'b1;

  always_comb begin
    nx_cmd  = C_NOP;
    nx_ba   = '0;
    nx_addr = '0;
    nx_gap  = CNT_W'(1);
    case (step)
      S_PWR:   begin nx_cmd = C_DESEL; nx_gap = t_pwrup; end
      S_NOP1:  nx_gap = t_clk_gap;
      S_NOP2:  nx_gap = CNT_W'(1);
      S_PRE1, S_PRE2: begin
        nx_cmd = C_PRE; nx_addr = M_ALLBANK; nx_gap = t_rp;
      end
      S_EMR2:  begin nx_cmd = C_LOAD; nx_ba = BA_W'(2); nx_addr = emr2_cfg; nx_gap = t_mrd; end
      S_EMR3:  begin nx_cmd = C_LOAD; nx_ba = BA_W'(3); nx_gap = t_mrd; end
      S_DLLEN: begin nx_cmd = C_LOAD; nx_ba = BA_W'(1); nx_addr = emr1_base; nx_gap = dll_gap; end
      S_MRRST: begin nx_cmd = C_LOAD; nx_addr = mr_cfg | M_DLLRST; nx_gap = t_mrd; end
      S_REF1, S_REF2: begin nx_cmd = C_REF; nx_gap = t_rfc; end
      S_MRRUN: begin nx_cmd = C_LOAD; nx_addr = mr_cfg & ~M_DLLRST; nx_gap = t_mrd; end
      S_OCDD:  begin nx_cmd = C_LOAD; nx_ba = BA_W'(1); nx_addr = emr1_base | M_OCD; nx_gap = t_mrd; end
      S_OCDX:  begin nx_cmd = C_LOAD; nx_ba = BA_W'(1); nx_addr = emr1_base; nx_gap = t_mrd; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step   <= S_PWR;
      cnt    <= '0;
      cmd_q  <= C_DESEL;
      ba_q   <= '0;
      addr_q <= '0;
      cke_q  <= 1'b0;
      done_q <= 1'b0;
      cmpl_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (step == S_IDLE) begin
        cmd_q  <= C_NOP;
        ba_q   <= '0;
        addr_q <= '0;
      end else if (cnt != '0) begin
        cnt    <= cnt - 1'b1;
        cmd_q  <= cke_q ? C_NOP : C_DESEL;
        ba_q   <= '0;
        addr_q <= '0;
      end else begin
        cmd_q  <= nx_cmd;
        ba_q   <= nx_ba;
        addr_q <= nx_addr;
        cnt    <= gap_m1;
        step   <= step + 1'b1;
        if (step == S_NOP1) cke_q <= 1'b1;
        if (step == S_DONE) begin
          done_q <= 1'b1;
          cmpl_q <= 1'b1;
        end
      end
    end
  end

  assign ddr_cke       = cke_q;
  assign {ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n} = cmd_q;
  assign ddr_ba        = ba_q;
  assign ddr_addr      = addr_q;
  assign init_done     = done_q;
  assign init_complete = cmpl_q;

endmodule

// File: rtl/ddr2_init_seq_chk.sv
module ddr2_init_seq_chk #(
  parameter int ADDR_W = 14,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CNT_W-1:0]  t_mrd,
  input logic              ddr_cke,
  input logic              ddr_cs_n,
  input logic              ddr_ras_n,
  input logic              ddr_cas_n,
  input logic              ddr_we_n,
  input logic [ADDR_W-1:0] ddr_addr,
  input logic              init_done,
  input logic              init_complete
);

  logic [3:0]       cmd;
  logic             is_load;
  logic [CNT_W-1:0] since_load;
  logic             seen_load;

  assign cmd     = {ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n};
  assign is_load = (cmd == 4'b0000);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_load <= '0;
      seen_load  <= 1'b0;
    end else begin
      seen_load <= seen_load | is_load;
      if (is_load) since_load <= CNT_W'(1);
      else if (since_load != '1) since_load <= since_load + 1'b1;
    end
  end

  assert_cke_stays_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ddr_cke |=> ddr_cke);

  assert_desel_while_cke_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ddr_cke |-> ddr_cs_n);

  assert_load_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (is_load && seen_load) |-> (since_load >= t_mrd));

  assert_prea_a10_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 4'b0010) |-> ddr_addr[10]);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> !init_done);

  assert_done_with_complete_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_complete) |-> init_done);

  assert_complete_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    init_complete |=> (init_complete && cmd == 4'b0111));

endmodule

bind ddr2_init_seq ddr2_init_seq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .t_mrd(t_mrd), .ddr_cke(ddr_cke),
  .ddr_cs_n(ddr_cs_n), .ddr_ras_n(ddr_ras_n), .ddr_cas_n(ddr_cas_n),
  .ddr_we_n(ddr_we_n), .ddr_addr(ddr_addr), .init_done(init_done),
  .init_complete(init_complete)
);

// File: tb/ddr2_init_seq_tb.sv
module ddr2_init_seq_tb_top;
  localparam int AW = 14;
  localparam int BW = 3;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CW-1:0] t_pwrup = '0, t_clk_gap = '0, t_rp = '0, t_rfc = '0, t_mrd = '0, t_dll = '0;
  logic [AW-1:0] mr_cfg = '0, emr1_cfg = '0, emr2_cfg = '0;
  logic ddr_cke, ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n, init_done, init_complete;
  logic [BW-1:0] ddr_ba;
  logic [AW-1:0] ddr_addr;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  ddr2_init_seq #(.ADDR_W(AW), .BA_W(BW), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .t_pwrup(t_pwrup), .t_clk_gap(t_clk_gap),
    .t_rp(t_rp), .t_rfc(t_rfc), .t_mrd(t_mrd), .t_dll(t_dll),
    .mr_cfg(mr_cfg), .emr1_cfg(emr1_cfg), .emr2_cfg(emr2_cfg),
    .ddr_cke(ddr_cke), .ddr_cs_n(ddr_cs_n), .ddr_ras_n(ddr_ras_n),
    .ddr_cas_n(ddr_cas_n), .ddr_we_n(ddr_we_n), .ddr_ba(ddr_ba),
    .ddr_addr(ddr_addr), .init_done(init_done), .init_complete(init_complete)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic int eff(input int x);
    return (x == 0) ? 1 : x;
  endfunction

  function automatic string tag_of(input int k);
    case (k)
      0, 1: return "R2/R3 NOP";
      2, 7: return "R3/R9 precharge";
      8, 9: return "R3/R9 refresh";
      3, 4: return "R4 EMRS2/EMRS3";
      5:    return "R5/R6 EMRS1 DLL enable";
      6, 10: return "R5 MRS";
      default: return "R5 EMRS1 OCD";
    endcase
  endfunction

  task automatic run_one(input int pw, input int cg, input int rp, input int rfc,
                         input int mrd, input int dll, input logic [AW-1:0] mr,
                         input logic [AW-1:0] e1, input logic [AW-1:0] e2,
                         input int abort_at, input string rtag);
    int g[13];
    int t[13];
    logic [3:0] ec[13];
    logic [BW-1:0] eb[13];
    logic [AW-1:0] ea[13];
    logic [AW-1:0] e1c;
    int tdone, last;
    bit idle_bad;
    @(negedge clk);
    rst_n = 1'b0;
    t_pwrup = CW'(pw); t_clk_gap = CW'(cg); t_rp = CW'(rp); t_rfc = CW'(rfc);
    t_mrd = CW'(mrd); t_dll = CW'(dll); mr_cfg = mr; emr1_cfg = e1; emr2_cfg = e2;
    @(negedge clk);
    total++;
    if (ddr_cke !== 1'b0 || {ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n} !== 4'b1111 ||
        init_done !== 1'b0 || init_complete !== 1'b0 || ddr_ba !== '0 || ddr_addr !== '0) begin
      bad++;
      $display("FAIL %s reset state: actual cke=%b cmd=%b done=%b cmpl=%b expected 0 1111 0 0",
               rtag, ddr_cke, {ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n}, init_done, init_complete);
    end
    e1c = e1 & ~AW'(14'h0381);
    for (int k = 0; k < 13; k++) begin ec[k] = 4'b0000; eb[k] = '0; ea[k] = '0; end
    ec[0] = 4'b0111; ec[1] = 4'b0111;
    ec[2] = 4'b0010; ea[2] = 14'h0400; ec[7] = 4'b0010; ea[7] = 14'h0400;
    ec[8] = 4'b0001; ec[9] = 4'b0001;
    eb[3] = 3'd2; ea[3] = e2;
    eb[4] = 3'd3; ea[4] = '0;
    eb[5] = 3'd1; ea[5] = e1c;
    eb[6] = 3'd0; ea[6] = mr | 14'h0100;
    eb[10] = 3'd0; ea[10] = mr & ~AW'(14'h0100);
    eb[11] = 3'd1; ea[11] = e1c | 14'h0380;
    eb[12] = 3'd1; ea[12] = e1c;
    g[0] = eff(cg); g[1] = 1; g[2] = eff(rp); g[3] = eff(mrd); g[4] = eff(mrd);
    g[5] = eff((dll > mrd) ? dll : mrd); g[6] = eff(mrd); g[7] = eff(rp);
    g[8] = eff(rfc); g[9] = eff(rfc); g[10] = eff(mrd); g[11] = eff(mrd); g[12] = eff(mrd);
    t[0] = 1 + eff(pw);
    for (int k = 1; k < 13; k++) t[k] = t[k-1] + g[k-1];
    tdone = t[12] + g[12];
    last = (abort_at > 0) ? abort_at : tdone + 3;
    idle_bad = 1'b0;
    rst_n = 1'b1;
    for (int n = 1; n <= last; n++) begin
      int kk;
      logic [3:0] xc;
      logic [BW-1:0] xb;
      logic [AW-1:0] xa;
      logic [3:0] ac;
      @(posedge clk);
      @(negedge clk);
      ac = {ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n};
      kk = -1;
      for (int k = 0; k < 13; k++) if (t[k] == n) kk = k;
      if (kk >= 0) begin
        total++;
        if (ac !== ec[kk] || ddr_ba !== eb[kk] || ddr_addr !== ea[kk] || ddr_cke !== 1'b1) begin
          bad++;
          $display("FAIL %s step %0d at cycle %0d: actual cmd=%b ba=%0d addr=%h cke=%b expected cmd=%b ba=%0d addr=%h cke=1 (R6/R7/R8 timing)",
                   tag_of(kk), kk, n, ac, ddr_ba, ddr_addr, ddr_cke, ec[kk], eb[kk], ea[kk]);
        end
      end else begin
        xc = (n < t[0]) ? 4'b1111 : 4'b0111;
        xb = '0; xa = '0;
        if (!idle_bad && (ac !== xc || ddr_ba !== xb || ddr_addr !== xa ||
                          ddr_cke !== (n >= t[0]))) begin
          idle_bad = 1'b1;
          $display("FAIL R1/R9 idle cycle %0d: actual cmd=%b ba=%0d addr=%h cke=%b expected cmd=%b ba=0 addr=0 cke=%b",
                   n, ac, ddr_ba, ddr_addr, ddr_cke, xc, (n >= t[0]));
        end
      end
      if (!idle_bad && (init_done !== (n == tdone) || init_complete !== (n >= tdone))) begin
        idle_bad = 1'b1;
        $display("FAIL R10 cycle %0d: actual done=%b cmpl=%b expected done=%b cmpl=%b",
                 n, init_done, init_complete, (n == tdone), (n >= tdone));
      end
    end
    total++;
    if (idle_bad) bad++;
  endtask

  initial begin
    int run;
    int pws[2] = '{0, 3};
    int cgs[2] = '{1, 2};
    int rps[2] = '{0, 2};
    int rfcs[2] = '{1, 4};
    int dlls[2] = '{0, 7};
    run = 0;
    repeat (3) @(negedge clk);
    foreach (pws[a]) foreach (cgs[b]) foreach (rps[c]) foreach (rfcs[d])
      for (int m = 1; m <= 3; m++) foreach (dlls[e]) begin
        string rt;
        int ab;
        rt = ((run % 5) == 1) ? "R11 restart" : "R1";
        ab = ((run % 5) == 0) ? ((run % 40) + 3) : 0;
        run_one(pws[a], cgs[b], rps[c], rfcs[d], m, dlls[e],
                AW'(run * 37 + 5), AW'(14'h3FFF - run * 53), AW'(run * 91 + 3), ab, rt);
        run++;
      end
    run_one(0, 0, 0, 0, 0, 0, AW'(14'h0123), AW'(14'h3FFF), AW'(14'h0080), 0, "R8 all zero");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule